// File: doc/BRIEF.md
# STS-3c Transmit Overhead and Pointer Inserter

This block builds the transmit side of a concatenated STS-3c / STM-1 frame, one byte at a time. An internal position counter steps through a frame of 9 rows by 270 columns, 2430 bytes, and advances once for each cycle in which the byte enable is high. For each position the block picks the outgoing byte. In row 0 it emits the framing bytes and the trace bytes. In row 3 it emits the pointer bytes, which are fixed: one normal pointer with offset 522 in the first H1/H2 pair and a concatenation indication in the other pairs. Every other overhead byte is zero. In the payload columns it passes the payload input through.

Two controls change the content. The unequipped control forces the payload to zero. The AIS control replaces both the pointer row and the payload with all ones, and takes precedence over the unequipped control. A frame-synchronous x^7+x^6+1 scrambler is XORed onto every byte except the row-0 framing and trace bytes. A single control bit turns the scrambler off.

The output is registered. A pulse on `frame_start_o` marks the first framing byte of each frame.

Top module: `sts3c_tx_oh_inserter`

## Requirements
- R1: While reset is active, and until the first enabled byte, `data_o` is 0x00 and `frame_start_o` is low. The first enabled byte after reset is the first byte of a frame (row 0, column 0).
- R2: Each frame holds 9 rows of 270 columns, 2430 enabled bytes, sent row by row. The byte for an enabled cycle appears on `data_o` after the next clock edge. `frame_start_o` is high for one cycle, together with row 0 column 0. When `byte_en_i` is low, `data_o` holds its value and `frame_start_o` is low.
- R3: In row 0 the block sends 0xF6 in columns 0-2, 0x28 in columns 3-5 and TRACE_BYTE (default 0x01) in columns 6-8. These nine bytes are never scrambled.
- R4: Row 3 carries the pointer bytes, before scrambling and without AIS. Column 0 is 0x62 (NDF 0110, SS 00, pointer bits 9:8 = 10). Column 3 is 0x0A (pointer bits 7:0, so the pointer value is 522). Columns 1-2 are 0x93 (NDF 1001, SS 00, bits 9:8 = 11). Columns 4-5 are 0xFF. Columns 6-8 are 0x00.
- R5: The overhead bytes in columns 0-8 of rows 1, 2 and 4-8 are 0x00 before scrambling.
- R6: In columns 9-269 of every row, the byte before scrambling is the `payload_i` value sampled with `byte_en_i`.
- R7: With `uneq_i` high and `ais_i` low, the payload columns are 0x00 before scrambling.
- R8: With `ais_i` high, all of row 3 and the payload columns are 0xFF before scrambling, whatever `uneq_i` is. Row-0 framing and trace bytes are unchanged.
- R9: The scrambler uses x^7+x^6+1. It is seeded to all ones at row 0 column 9 and produces its output MSB first. It advances 8 bits for each enabled byte outside row-0 columns 0-8, and the keystream is XORed onto the data. The first two keystream bytes are 0xFE and 0x04.
- R10: With `scr_inh_i` high, the keystream is not XORed onto the data, but the scrambler keeps its frame-synchronous phase. Clearing `scr_inh_i` in the middle of a frame resumes scrambling with the same keystream byte that would have been used at that position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| byte_en_i | input | 1 | Produces one output byte and advances the frame position |
| payload_i | input | 8 | Payload byte, sampled with byte_en_i in the payload columns |
| ais_i | input | 1 | Sends path AIS (all ones in the pointer row and the payload) |
| uneq_i | input | 1 | Sends an unequipped payload (all zeros) |
| scr_inh_i | input | 1 | Turns off the scrambler XOR |
| frame_start_o | output | 1 | One-cycle pulse with the first framing byte |
| data_o | output | 8 | Outgoing frame byte |

## Verification
The hardest thing to reach from the ports is the scrambler phase. It depends on every enabled byte since the seed point. A keystream that is off by one byte, or that steps during disabled cycles, only shows up deep in a frame. The bench therefore runs whole frames with the scrambler on, both with a continuous enable and with an enable that has regular gaps. It compares each byte against its own model of the seeded sequence. It also clears `scr_inh_i` halfway through a frame to show that the phase kept running while the XOR was off.

// File: rtl/sts_tx_pkg.sv
package sts_tx_pkg;
  localparam logic [7:0] FRAME_A1  = 8'hF6;
  localparam logic [7:0] FRAME_A2  = 8'h28;
  // first pair: NDF 0110, SS 00, offset 10_0000_1010 (522)
  localparam logic [7:0] H1_PTR    = {4'b0110, 2'b00, 2'b10};
  localparam logic [7:0] H2_PTR    = 8'h0A;
  // concatenation indication: NDF 1001, SS 00, offset all ones
  localparam logic [7:0] H1_CAT    = {4'b1001, 2'b00, 2'b11};
  localparam logic [7:0] H2_CAT    = 8'hFF;
  localparam int         PTR_ROW   = 3;
  localparam int         SCR_BITS  = 7;
  localparam logic [SCR_BITS-1:0] SCR_SEED = '1;
endpackage

// File: rtl/sts_pos_cnt.sv
module sts_pos_cnt #(
  parameter int ROWS  = 9,
  parameter int COLS  = 270,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic             first_o
);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else if (en_i) begin
      if (col_q == COL_LAST) begin
        col_q <= '0;
        row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  assign row_o   = row_q;
  assign col_o   = col_q;
  assign first_o = (row_q == '0) && (col_q == '0);
endmodule

// File: rtl/sts_oh_mux.sv
module sts_oh_mux
  import sts_tx_pkg::*;
#(
  parameter int         N_STS      = 3,
  parameter int         ROW_W      = 4,
  parameter int         COL_W      = 9,
  parameter logic [7:0] TRACE_BYTE = 8'h01
) (
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [7:0]       payload_i,
  input  logic             ais_i,
  input  logic             uneq_i,
  output logic [7:0]       raw_o,
  output logic             scr_zone_o,
  output logic             seed_o
);
  localparam logic [COL_W-1:0] C_N   = COL_W'(N_STS);
  localparam logic [COL_W-1:0] C_2N  = COL_W'(2 * N_STS);
  localparam logic [COL_W-1:0] C_TOH = COL_W'(3 * N_STS);
  localparam logic [ROW_W-1:0] R_PTR = ROW_W'(PTR_ROW);

  always_comb begin
    raw_o      = 8'h00;
    scr_zone_o = 1'b1;
    if (col_i < C_TOH) begin
      if (row_i == '0) begin
        scr_zone_o = 1'b0;
        if (col_i < C_N)       raw_o = FRAME_A1;
        else if (col_i < C_2N) raw_o = FRAME_A2;
        else                   raw_o = TRACE_BYTE;
      end else if (row_i == R_PTR) begin
        if (ais_i)              raw_o = 8'hFF;
        else if (col_i == '0)   raw_o = H1_PTR;
        else if (col_i < C_N)   raw_o = H1_CAT;
        else if (col_i == C_N)  raw_o = H2_PTR;
        else if (col_i < C_2N)  raw_o = H2_CAT;
        else                    raw_o = 8'h00;  // H3: no justification
      end
    end else begin
      raw_o = ais_i ? 8'hFF : (uneq_i ? 8'h00 : payload_i);
    end
  end

  assign seed_o = (row_i == '0) && (col_i == C_TOH);
endmodule

// File: rtl/sts_frame_scr.sv
module sts_frame_scr
  import sts_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic       seed_i,
  output logic [7:0] key_o
);
  logic [SCR_BITS-1:0] st_q;
  logic [SCR_BITS-1:0] chain [0:8];

  assign chain[0] = seed_i ? SCR_SEED : st_q;

  for (genvar g = 0; g < 8; g++) begin : g_bit
    assign key_o[7-g]  = chain[g][SCR_BITS-1];
    assign chain[g+1]  = {chain[g][SCR_BITS-2:0],
                          chain[g][SCR_BITS-1] ^ chain[g][SCR_BITS-2]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= SCR_SEED;
    else if (step_i) st_q <= chain[8];
  end
endmodule

// File: rtl/sts3c_tx_oh_inserter.sv
module sts3c_tx_oh_inserter #(
  parameter int         N_STS      = 3,
  parameter int         ROWS       = 9,
  parameter logic [7:0] TRACE_BYTE = 8'h01
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       byte_en_i,
  input  logic [7:0] payload_i,
  input  logic       ais_i,
  input  logic       uneq_i,
  input  logic       scr_inh_i,
  output logic       frame_start_o,
  output logic [7:0] data_o
);
  localparam int COLS  = 90 * N_STS;
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);

  logic [ROW_W-1:0] row_w;
  logic [COL_W-1:0] col_w;
  logic             first_w, scr_zone_w, seed_w;
  logic [7:0]       raw_w, key_w;
  logic [7:0]       data_q;
  logic             fs_q;

  sts_pos_cnt #(.ROWS(ROWS), .COLS(COLS)) i_pos (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (byte_en_i),
    .row_o  (row_w),
    .col_o  (col_w),
    .first_o(first_w)
  );

  sts_oh_mux #(
    .N_STS(N_STS), .ROW_W(ROW_W), .COL_W(COL_W), .TRACE_BYTE(TRACE_BYTE)
  ) i_mux (
    .row_i     (row_w),
    .col_i     (col_w),
    .payload_i (payload_i),
    .ais_i     (ais_i),
    .uneq_i    (uneq_i),
    .raw_o     (raw_w),
    .scr_zone_o(scr_zone_w),
    .seed_o    (seed_w)
  );

  sts_frame_scr i_scr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(byte_en_i && scr_zone_w),
    .seed_i(seed_w),
    .key_o (key_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= 8'h00;
      fs_q   <= 1'b0;
    end else if (byte_en_i) begin
      data_q <= raw_w ^ ((scr_zone_w && !scr_inh_i) ? key_w : 8'h00);
      fs_q   <= first_w;
    end else begin
      fs_q   <= 1'b0;
    end
  end

  assign data_o        = data_q;
  assign frame_start_o = fs_q;
endmodule

// File: rtl/sts3c_tx_oh_checker.sv
module sts3c_tx_oh_checker #(
  parameter int N_STS = 3,
  parameter int ROWS  = 9,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(90 * N_STS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             byte_en_i,
  input logic             ais_i,
  input logic             uneq_i,
  input logic             scr_inh_i,
  input logic [ROW_W-1:0] row_i,
  input logic [COL_W-1:0] col_i,
  input logic             frame_start_i,
  input logic [7:0]       data_i
);
  localparam logic [COL_W-1:0] C_TOH = COL_W'(3 * N_STS);
  localparam logic [ROW_W-1:0] R_PTR = ROW_W'(3);

  p_fs_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |-> $past(byte_en_i));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_en_i |=> ($stable(data_i) && !frame_start_i));

  p_fs_a1_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |-> (data_i == 8'hF6));

  p_ptr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_en_i && scr_inh_i && !ais_i && row_i == R_PTR && col_i == '0)
    |=> (data_i == 8'h62));

  p_uneq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_en_i && scr_inh_i && uneq_i && !ais_i && col_i >= C_TOH)
    |=> (data_i == 8'h00));

  p_ais_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_en_i && scr_inh_i && ais_i && (col_i >= C_TOH || row_i == R_PTR))
    |=> (data_i == 8'hFF));

  p_seed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_en_i && !scr_inh_i && !ais_i && uneq_i && row_i == '0 && col_i == C_TOH)
    |=> (data_i == 8'hFE));
endmodule

bind sts3c_tx_oh_inserter sts3c_tx_oh_checker #(.N_STS(N_STS), .ROWS(ROWS)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .byte_en_i    (byte_en_i),
  .ais_i        (ais_i),
  .uneq_i       (uneq_i),
  .scr_inh_i    (scr_inh_i),
  .row_i        (row_w),
  .col_i        (col_w),
  .frame_start_i(frame_start_o),
  .data_i       (data_o)
);

// File: tb/test_sts3c_tx_oh_inserter.sv
module test_sts3c_tx_oh_inserter;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NROW = 9;
  localparam int  NCOL = 270;
  localparam int  TOH  = 9;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       byte_en_i = 1'b0;
  logic [7:0] payload_i = 8'h00;
  logic       ais_i = 1'b0;
  logic       uneq_i = 1'b0;
  logic       scr_inh_i = 1'b1;
  logic       frame_start_o;
  logic [7:0] data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int         m_row = 0;
  int         m_col = 0;
  logic [6:0] m_scr = 7'h7F;
  logic [7:0] last_exp = 8'h00;
  int         n_fs = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  sts3c_tx_oh_inserter i_sts3c_tx_oh_inserter (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_en_i(byte_en_i), .payload_i(payload_i),
    .ais_i(ais_i), .uneq_i(uneq_i), .scr_inh_i(scr_inh_i),
    .frame_start_o(frame_start_o), .data_o(data_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s row %0d col %0d: got 0x%0h expected 0x%0h", req, m_row, m_col, act, exp);
    end
  endtask

  function automatic logic [7:0] raw_exp(int r, int c, logic [7:0] pl, bit ais, bit uq);
    if (r == 0 && c < TOH) return (c < 3) ? 8'hF6 : (c < 6) ? 8'h28 : 8'h01;
    if (r == 3 && c < TOH) begin
      if (ais) return 8'hFF;
      case (c)
        0: return 8'h62;
        1, 2: return 8'h93;
        3: return 8'h0A;
        4, 5: return 8'hFF;
        default: return 8'h00;
      endcase
    end
    if (c < TOH) return 8'h00;
    if (ais) return 8'hFF;
    if (uq) return 8'h00;
    return pl;
  endfunction

  function automatic string tag_of(int r, int c, bit ais, bit uq, bit inh);
    if (r == 0 && c < TOH) return "R3";
    if (r == 3 && c < TOH) return ais ? "R8" : "R4";
    if (c < TOH) return "R5";
    if (!inh) return (r == 0 && c < TOH + 2) ? "R9" : "R10";
    if (ais) return "R8";
    if (uq) return "R7";
    return "R6";
  endfunction

  // one clock: drive at negedge, check at next negedge
  task automatic step(input bit en, input logic [7:0] pl);
    logic [7:0] exp_b, key;
    bit         exp_fs;
    string      tg;
    byte_en_i = en;
    payload_i = pl;
    exp_fs = 1'b0;
    tg = "R2";
    exp_b = last_exp;
    if (en) begin
      exp_fs = (m_row == 0 && m_col == 0);
      exp_b = raw_exp(m_row, m_col, pl, ais_i, uneq_i);
      tg = tag_of(m_row, m_col, ais_i, uneq_i, scr_inh_i);
      if (!(m_row == 0 && m_col < TOH)) begin
        if (m_row == 0 && m_col == TOH) m_scr = 7'h7F;
        for (int k = 7; k >= 0; k--) begin
          key[k] = m_scr[6];
          m_scr = {m_scr[5:0], m_scr[6] ^ m_scr[5]};
        end
        if (!scr_inh_i) exp_b = exp_b ^ key;
      end
    end
    @(posedge clk_i);
    @(negedge clk_i);
    chk(data_o == exp_b, tg, data_o, exp_b);
    chk(frame_start_o == exp_fs, "R2", frame_start_o, exp_fs);
    if (frame_start_o) n_fs++;
    last_exp = exp_b;
    if (en) begin
      if (m_col == NCOL - 1) begin
        m_col = 0;
        m_row = (m_row == NROW - 1) ? 0 : m_row + 1;
      end else m_col++;
    end
  endtask

  task automatic t_reset;
    chk(data_o == 8'h00, "R1", data_o, 0);
    chk(frame_start_o == 1'b0, "R1", frame_start_o, 0);
    rst_ni = 1'b1;
    step(1'b0, 8'h5A);
    chk(data_o == 8'h00, "R1", data_o, 0);
  endtask

  task automatic t_plain;   // R2 R3 R4 R5 R6
    scr_inh_i = 1'b1;
    for (int i = 0; i < NROW * NCOL; i++) step(1'b1, 8'((i * 7) ^ (i >> 3)));
  endtask

  task automatic t_scrambled;   // R9
    scr_inh_i = 1'b0;
    uneq_i = 1'b1;
    for (int i = 0; i < NROW * NCOL; i++) begin
      step(1'b1, 8'(i));
      if (i == TOH)     chk(data_o == 8'hFE, "R9", data_o, 8'hFE);
      if (i == TOH + 1) chk(data_o == 8'h04, "R9", data_o, 8'h04);
    end
    uneq_i = 1'b0;
  endtask

  task automatic t_uneq;   // R7
    scr_inh_i = 1'b1;
    uneq_i = 1'b1;
    for (int i = 0; i < NROW * NCOL; i++) step(1'b1, 8'hA5);
    uneq_i = 1'b0;
  endtask

  task automatic t_ais;   // R8, AIS over unequipped, with scrambling
    scr_inh_i = 1'b0;
    ais_i = 1'b1;
    uneq_i = 1'b1;
    for (int i = 0; i < NROW * NCOL; i++) step(1'b1, 8'h3C);
    ais_i = 1'b0;
    uneq_i = 1'b0;
  endtask

  task automatic t_gaps_inh;   // R2 hold, R10 phase kept while inhibited
    int fs0;
    fs0 = n_fs;
    scr_inh_i = 1'b1;
    for (int i = 0; i < NROW * NCOL; i++) begin
      if (i == 1200) scr_inh_i = 1'b0;
      step(1'b1, 8'(i + 3));
      if (i % 3 == 0) step(1'b0, 8'hEE);
    end
    chk(n_fs - fs0 == 1, "R2", n_fs - fs0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    t_plain();
    t_scrambled();
    t_uneq();
    t_ais();
    t_gaps_inh();
    chk(n_fs == 5, "R2", n_fs, 5);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule